// File: doc/BRIEF.md
# Latched Chip-Select Bus Front End

This block is the host-facing front end of a small peripheral. It decodes three chip-select inputs that have mixed polarity. It holds the decoded select and a 3-bit register index in latches that an active-low address strobe opens, so the block works on multiplexed buses. Holding the strobe low permanently gives non-multiplexed operation. Read and write requests can arrive on either an active-high or an active-low strobe of each kind. The block turns each accepted request into one single-cycle pulse, which a register file consumes together with the latched index. It also drives a select indicator and a driver-disable output that an external transceiver can use.

All inputs are sampled on the rising edge of `clk`. The capture registers model the transparent latches: they load on every edge at which `as_n` is low and hold otherwise. The combined strobe levels pass through a `SYNC_STAGES`-deep synchroniser into a four-state access machine:

- `ST_IDLE` waits for a request.
- `ST_RD_PULSE` emits the read pulse for exactly one cycle.
- `ST_WR_PULSE` emits the write pulse for exactly one cycle.
- `ST_HOLD` waits until every strobe is released.

Transitions:

- IDLE→RD_PULSE: a read alone is requested and the select is valid.
- IDLE→WR_PULSE: a write alone is requested and the select is valid.
- IDLE→HOLD: any other request, meaning the select is invalid or read and write are requested together.
- RD_PULSE→HOLD and WR_PULSE→HOLD: always, after the one pulse cycle.
- HOLD→IDLE: both synchronised requests are low.

Top module: `hbf_bus_front`

## Requirements
- R1: The select is valid only when `sel_a`=1, `sel_b`=1 and `sel_n`=0 at capture; any other combination captures an invalid select.
- R2: On a clock edge with `as_n` low, the select decode and `addr` are captured. `sel_out` and `reg_idx` show them after that edge.
- R3: While `as_n` is high, `sel_out` and `reg_idx` keep their values whatever the select and address inputs do.
- R4: With `as_n` held low, the block tracks the select and address inputs continuously (non-multiplexed mode).
- R5: A read is requested by `rd_p`=1 or `rd_n`=0. With a valid select, each request produces exactly one `rd_pulse`, and `reg_idx` holds the captured index during that pulse.
- R6: A write is requested by `wr_p`=1 or `wr_n`=0. With a valid select, each request produces exactly one `wr_pulse`, and `reg_idx` holds the captured index during that pulse.
- R7: A request that begins while the select is invalid produces no pulse. This holds even if the select becomes valid before the strobe is released.
- R8: `drv_dis` is 0 while the synchronised read request is active and the select is valid. It is 1 at all other times.
- R9: Read and write requested together produce neither pulse.
- R10: Reset clears the latches to the deselected state: `sel_out`=0, `reg_idx`=0, `drv_dis`=1 and no pulses.
- R11: Each pulse is one clock cycle wide, and `rd_pulse` and `wr_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high, synchronous |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_n | input | 1 | Chip select, active low |
| addr | input | AW | Register address |
| as_n | input | 1 | Address strobe, active low; latches transparent while low |
| rd_p | input | 1 | Read strobe, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_p | input | 1 | Write strobe, active high |
| wr_n | input | 1 | Write strobe, active low |
| sel_out | output | 1 | Latched select is valid |
| drv_dis | output | 1 | Low while the host reads the device |
| rd_pulse | output | 1 | One-cycle qualified read |
| wr_pulse | output | 1 | One-cycle qualified write |
| reg_idx | output | AW | Latched register index |

## Verification
The bench scrambles the select and address inputs while the address strobe is high. A latch left transparent would move `reg_idx` and produce pulses tagged with the wrong register. It holds a read strobe through a deselected-to-selected transition; a design that re-evaluates the select in a hold state would emit a late pulse there. Simultaneous read and write requests, each strobe polarity, and a long-held strobe catch designs that pulse on a level rather than on an edge, or that emit two pulses. A reset in the middle of a run checks that a previously valid select is dropped.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_PULSE,
        ST_WR_PULSE,
        ST_HOLD
    } acc_state_e;
endpackage

// File: rtl/hbf_addr_latch.sv
module hbf_addr_latch #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          as_n,
    input  logic          sel_a,
    input  logic          sel_b,
    input  logic          sel_n,
    input  logic [AW-1:0] addr,
    output logic          sel_q,
    output logic [AW-1:0] idx_q
);
    logic sel_dec;

    // R1: two active-high selects, one active-low
    always_comb sel_dec = sel_a & sel_b & ~sel_n;

    // R2/R4: capture whenever the address strobe is low
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            idx_q <= '0;
        end else if (!as_n) begin
            sel_q <= sel_dec;
            idx_q <= addr;
        end
    end

    a_r3_hold_while_closed: assert property (@(posedge clk) disable iff (rst)
        as_n |=> ($stable(sel_q) && $stable(idx_q)));
endmodule

// File: rtl/hbf_strobe_sync.sv
module hbf_strobe_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[STAGES-2:0], d[b]};
        end
        assign q[b] = pipe[LAST];
    end
endmodule

// File: rtl/hbf_access_fsm.sv
module hbf_access_fsm
    import hbf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_s,
    input  logic wr_s,
    input  logic sel_ok,
    output logic rd_pulse,
    output logic wr_pulse
);
    acc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_s || wr_s) begin
                    if (sel_ok && rd_s && !wr_s)      state_d = ST_RD_PULSE;
                    else if (sel_ok && wr_s && !rd_s) state_d = ST_WR_PULSE;
                    else                              state_d = ST_HOLD;
                end
            end
            ST_RD_PULSE: state_d = ST_HOLD;
            ST_WR_PULSE: state_d = ST_HOLD;
            ST_HOLD:     if (!rd_s && !wr_s) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        rd_pulse = (state_q == ST_RD_PULSE);
        wr_pulse = (state_q == ST_WR_PULSE);
    end

    a_r11_rd_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rd_pulse |=> !rd_pulse);
    a_r11_wr_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);
    a_r7_no_pulse_unselected: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !sel_ok) |=> (!rd_pulse && !wr_pulse));
    a_r9_conflict_drops: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && rd_s && wr_s) |=> (!rd_pulse && !wr_pulse));
endmodule

// File: rtl/hbf_bus_front.sv
module hbf_bus_front #(
    parameter int AW          = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_a,
    input  logic          sel_b,
    input  logic          sel_n,
    input  logic [AW-1:0] addr,
    input  logic          as_n,
    input  logic          rd_p,
    input  logic          rd_n,
    input  logic          wr_p,
    input  logic          wr_n,
    output logic          sel_out,
    output logic          drv_dis,
    output logic          rd_pulse,
    output logic          wr_pulse,
    output logic [AW-1:0] reg_idx
);
    localparam int RD_BIT = 0;
    localparam int WR_BIT = 1;

    logic [1:0] req_raw;
    logic [1:0] req_s;

    always_comb begin
        req_raw[RD_BIT] = rd_p | ~rd_n;
        req_raw[WR_BIT] = wr_p | ~wr_n;
    end

    hbf_addr_latch #(.AW(AW)) u_latch (
        .clk(clk), .rst(rst), .as_n(as_n),
        .sel_a(sel_a), .sel_b(sel_b), .sel_n(sel_n),
        .addr(addr), .sel_q(sel_out), .idx_q(reg_idx)
    );

    hbf_strobe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(req_raw), .q(req_s)
    );

    hbf_access_fsm u_fsm (
        .clk(clk), .rst(rst),
        .rd_s(req_s[RD_BIT]), .wr_s(req_s[WR_BIT]),
        .sel_ok(sel_out),
        .rd_pulse(rd_pulse), .wr_pulse(wr_pulse)
    );

    // R8: low only during a selected read
    always_comb drv_dis = ~(sel_out & req_s[RD_BIT]);

    a_r8_drv_only_selected: assert property (@(posedge clk) disable iff (rst)
        !drv_dis |-> sel_out);
    a_r5_rd_needs_select: assert property (@(posedge clk) disable iff (rst)
        rd_pulse |-> $past(sel_out));
endmodule

// File: tb/hbf_bus_front_tb_top.sv
module hbf_bus_front_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst;
    logic sel_a, sel_b, sel_n, as_n, rd_p, rd_n, wr_p, wr_n;
    logic [AW-1:0] addr;
    logic sel_out, drv_dis, rd_pulse, wr_pulse;
    logic [AW-1:0] reg_idx;

    int n_checks = 0;
    int n_errs = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int last_idx = 0;
    bit shape_bad = 0;
    logic prev_rd = 0;
    logic prev_wr = 0;

    hbf_bus_front #(.AW(AW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .sel_n(sel_n),
        .addr(addr), .as_n(as_n), .rd_p(rd_p), .rd_n(rd_n), .wr_p(wr_p),
        .wr_n(wr_n), .sel_out(sel_out), .drv_dis(drv_dis),
        .rd_pulse(rd_pulse), .wr_pulse(wr_pulse), .reg_idx(reg_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst === 1'b0) begin
            if (rd_pulse) begin rd_cnt++; last_idx = int'(reg_idx); end
            if (wr_pulse) begin wr_cnt++; last_idx = int'(reg_idx); end
            if ((rd_pulse && prev_rd) || (wr_pulse && prev_wr) || (rd_pulse && wr_pulse))
                shape_bad = 1;
        end
        prev_rd = rd_pulse;
        prev_wr = wr_pulse;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_sel(input bit a, input bit b, input bit n);
        return (a && b && !n) ? 1 : 0;
    endfunction

    task automatic latch_cfg(input bit a, input bit b, input bit n, input int ad);
        @(negedge clk);
        sel_a = a; sel_b = b; sel_n = n; addr = AW'(ad); as_n = 0;
        @(negedge clk);
        as_n = 1;
    endtask

    // kind: 0 read, 1 write, 2 both
    task automatic access(input int kind, input bit alt, input bit scramble,
                          input int esel, input int eidx, input string tag);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; shape_bad = 0;
        if (kind != 1) begin if (alt) rd_n = 0; else rd_p = 1; end
        if (kind != 0) begin if (alt) wr_n = 0; else wr_p = 1; end
        if (scramble) begin
            sel_a = 1'($urandom); sel_b = 1'($urandom); sel_n = 1'($urandom);
            addr = AW'($urandom);
        end
        repeat (6) @(negedge clk);
        chk({tag, " R8 drv_dis"}, int'(drv_dis), (kind != 1 && esel == 1) ? 0 : 1);
        rd_p = 0; rd_n = 1; wr_p = 0; wr_n = 1;
        repeat (6) @(negedge clk);
        chk({tag, " R5 rd count"}, rd_cnt, (kind == 0) ? esel : 0);
        chk({tag, " R6 wr count"}, wr_cnt, (kind == 1) ? esel : 0);
        if (kind != 2 && esel == 1)
            chk({tag, " R3 idx at pulse"}, last_idx, eidx);
        chk({tag, " R11 pulse shape"}, int'(shape_bad), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        rst = 1; as_n = 1; sel_a = 0; sel_b = 0; sel_n = 1; addr = '0;
        rd_p = 0; rd_n = 1; wr_p = 0; wr_n = 1;
        repeat (3) @(negedge clk);
        chk("R10 reset sel_out", int'(sel_out), 0);
        chk("R10 reset reg_idx", int'(reg_idx), 0);
        chk("R10 reset drv_dis", int'(drv_dis), 1);
        rst = 0;

        // R1/R2 directed decode
        latch_cfg(1, 1, 0, 5);
        @(negedge clk);
        chk("R1 R2 valid select", int'(sel_out), 1);
        chk("R2 index capture", int'(reg_idx), 5);
        latch_cfg(1, 1, 1, 2);
        @(negedge clk);
        chk("R1 sel_n high deselects", int'(sel_out), 0);
        latch_cfg(0, 1, 0, 2);
        @(negedge clk);
        chk("R1 sel_a low deselects", int'(sel_out), 0);

        // R5/R6 both polarities with scrambled inputs (R3)
        latch_cfg(1, 1, 0, 6);
        access(0, 0, 1, 1, 6, "rd_p");
        access(0, 1, 1, 1, 6, "rd_n");
        access(1, 0, 1, 1, 6, "wr_p");
        access(1, 1, 1, 1, 6, "wr_n");
        chk("R3 idx held", int'(reg_idx), 6);
        access(2, 0, 0, 1, 6, "R9 both");

        // R7: strobe begins deselected, select becomes valid while held
        latch_cfg(1, 0, 0, 3);
        @(negedge clk);
        rd_cnt = 0;
        rd_p = 1;
        repeat (6) @(negedge clk);
        latch_cfg(1, 1, 0, 3);
        repeat (6) @(negedge clk);
        rd_p = 0;
        repeat (6) @(negedge clk);
        chk("R7 late select no pulse", rd_cnt, 0);
        access(0, 0, 0, 1, 3, "R7 follow-up");

        // R4 non-multiplexed: strobe held low
        @(negedge clk);
        as_n = 0; sel_a = 1; sel_b = 1; sel_n = 0; addr = 3'd7;
        repeat (2) @(negedge clk);
        chk("R4 tracks sel", int'(sel_out), 1);
        chk("R4 tracks idx", int'(reg_idx), 7);
        access(1, 1, 0, 1, 7, "R4 write");
        addr = 3'd1; sel_n = 1;
        repeat (2) @(negedge clk);
        chk("R4 tracks deselect", int'(sel_out), 0);
        access(0, 0, 0, 0, 1, "R4 deselected read");
        as_n = 1;

        // random mix
        for (int i = 0; i < 40; i++) begin
            bit a, b, n, alt;
            int ad, kind;
            a = 1'($urandom); b = 1'($urandom); n = 1'($urandom);
            if (i % 3 == 0) begin a = 1; b = 1; n = 0; end
            ad = int'($urandom % 8);
            kind = int'($urandom % 3);
            alt = 1'($urandom);
            latch_cfg(a, b, n, ad);
            access(kind, alt, 1, exp_sel(a, b, n), ad, "random");
        end

        // R10 reset mid run
        latch_cfg(1, 1, 0, 4);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        chk("R10 mid reset sel_out", int'(sel_out), 0);
        chk("R10 mid reset reg_idx", int'(reg_idx), 0);
        rst = 0;
        access(0, 0, 0, 0, 0, "R10 after reset");

        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule